// File: doc/BRIEF.md
# Byte-Wide SPI Port with Bus-Contention Fallback

This block is a byte-oriented SPI peripheral. One control bit selects its role. As master, a write to the data register starts an eight-bit transfer that sends the most significant bit first in SPI mode 0. The clock idles low, data is sampled on the rising edge and changed on the falling edge. The byte returned by the far end lands in the same data register. As slave, the block follows an external clock. The incoming select line gates all of its activity and realigns its bit counter at byte boundaries.

The select pin matters in both roles. In slave role it is always an input. A high level keeps the block passive with its data output released. A rising select aborts any byte in flight. In master role software can make the pin a plain output. It can also leave the pin as an input that watches for contention. A low level on that input means another master has taken the bus. The block then drops to slave role, releases its clock and data outputs, and raises the completion flag. Software talks to the block through three byte registers: control at address 0, status at address 1 and data at address 2.

Top module: `spi_port`

## Requirements
- R1: After reset, control reads 0, status reads 0, `irq` is low and every output enable (`sck_oe`, `mosi_oe`, `miso_oe`, `ss_oe`) is low.
- R2: With control bit 0 (enable) and bit 1 (master) set, a data-register write starts an 8-bit MSB-first mode-0 transfer. MOSI is valid before each rising SCK and MISO is sampled on the rising edge. The received byte becomes readable at the data register, and status bit 7 (complete flag) sets after the eighth falling edge.
- R3: In master role SCK idles low and its period is 2*DIV_HALF system clocks.
- R4: The complete flag clears only when a status read that sees it set is followed by a data-register access. A data access alone leaves it set.
- R5: `irq` equals the complete flag ANDed with control bit 2 (interrupt enable) and the `glb_irq_en` input.
- R6: In master role with control bit 3 (select drive) set, `ss_oe` is high and `ss_o` follows control bit 4. A low `ss_i` then has no effect on the transfer or the master bit.
- R7: In master role with bit 3 clear, a low `ss_i` clears the master bit, drops `sck_oe` and `mosi_oe`, aborts the transfer and sets the complete flag.
- R8: After such a fault the block stays in slave role when `ss_i` returns high, until software writes the master bit again.
- R9: In slave role, while `ss_i` is high, `miso_oe` stays low and SCK activity receives nothing: no flag is set and the data register is unchanged.
- R10: In slave role with `ss_i` low, `miso_oe` is high only if control bit 5 (MISO enable) is set. A byte written to the data register before the transfer goes out MSB first on `miso_o`, the MOSI byte is received, and the flag sets after eight rising SCK edges.
- R11: In slave role, `ss_i` rising mid-byte discards the partial byte without setting the flag. The next selected byte is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK pad output |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO pad output |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Select pad input |
| ss_o | output | 1 | Select pad output |
| ss_oe | output | 1 | Select output enable |

## Verification
A bit counter that goes wrong shows at the ports as a shifted or rotated data byte. It can also show as a flag that comes one SCK edge early or late, or never. A missed select abort shows as a corrupt byte on the next selected transfer. A stuck role bit shows within three system clocks of a select change, because the output enables and the control readback give it away. The bench checks the captured MOSI and MISO bit streams, the received bytes and the clock period against values it computes itself. It also checks the enable and flag state a few cycles after each select edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_STAT = 2'd1;
  localparam logic [REG_AW-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic miso_en;   // bit 5
    logic ss_level;  // bit 4
    logic ss_drive;  // bit 3
    logic irq_en;    // bit 2
    logic master;    // bit 1
    logic en;        // bit 0
  } ctrl_t;

  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= INIT[i];
        s2 <= INIT[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi_port_master.sv
module spi_port_master
  import spi_port_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] div_q;
  logic          sck_q, busy_q, smp_q;
  logic [2:0]    cnt_q;
  logic [7:0]    sh_q;
  logic          tick;

  assign tick    = busy_q && (div_q == DIV_LAST);
  assign done    = tick && sck_q && (cnt_q == 3'd7);
  assign rx_byte = shift_in(sh_q, smp_q);
  assign sck     = sck_q;
  assign mosi    = sh_q[7];
  assign busy    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; sck_q <= 1'b0; busy_q <= 1'b0;
      smp_q <= 1'b0; cnt_q <= '0; sh_q <= '0;
    end else if (!run) begin
      div_q <= '0; sck_q <= 1'b0; busy_q <= 1'b0; cnt_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1; sh_q <= tx_byte; div_q <= '0;
      cnt_q <= '0; sck_q <= 1'b0;
    end else if (busy_q) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          smp_q <= miso;
        end else begin
          sck_q <= 1'b0;
          sh_q  <= shift_in(sh_q, smp_q);
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) busy_q <= 1'b0;
        end
      end
    end
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !busy_q) |=> busy_q);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
endmodule

// File: rtl/spi_port_slave.sv
module spi_port_slave
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ss_s,
  input  logic       sck_s,
  input  logic       mosi_s,
  input  logic       load,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [2:0] cnt_q;
  logic [7:0] sh_q;
  logic       sck_d;
  logic       rise, act;

  assign act     = run && !ss_s;
  assign rise    = sck_s && !sck_d;
  assign done    = act && rise && (cnt_q == 3'd7);
  assign rx_byte = shift_in(sh_q, mosi_s);
  assign miso    = sh_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; sh_q <= '0; sck_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (!act) begin
        cnt_q <= '0;
        if (load) sh_q <= tx_byte;
      end else if (rise) begin
        sh_q  <= shift_in(sh_q, mosi_s);
        cnt_q <= cnt_q + 3'd1;
      end else if (load && cnt_q == 3'd0) begin
        sh_q <= tx_byte;
      end
    end
  end

  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ss_s) |=> (cnt_q == 3'd0));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       glb_irq_en,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_i,
  output logic       ss_o,
  output logic       ss_oe
);
  ctrl_t      ctrl_q;
  logic       flag_q, armed_q;
  logic [7:0] rxbuf_q;
  logic       sck_s, mosi_s, ss_s;
  logic       m_run, s_run, m_busy, m_done, s_done, m_fault;
  logic       m_start, s_load, data_acc;
  logic [7:0] m_rx, s_rx;

  spi_port_sync #(.W(3), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_i, mosi_i, sck_i}), .q({ss_s, mosi_s, sck_s}));

  assign m_run    = ctrl_q.en && ctrl_q.master;
  assign s_run    = ctrl_q.en && !ctrl_q.master;
  assign m_fault  = m_run && !ctrl_q.ss_drive && !ss_s;
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == A_DATA);
  assign m_start  = reg_wr && (reg_addr == A_DATA) && m_run && !m_fault;
  assign s_load   = reg_wr && (reg_addr == A_DATA) && s_run;

  spi_port_master #(.DIV_HALF(DIV_HALF)) u_mst (
    .clk(clk), .rst_n(rst_n), .run(m_run && !m_fault), .start(m_start),
    .tx_byte(reg_wdata), .miso(miso_i), .sck(sck_o), .mosi(mosi_o),
    .busy(m_busy), .done(m_done), .rx_byte(m_rx));

  spi_port_slave u_slv (
    .clk(clk), .rst_n(rst_n), .run(s_run), .ss_s(ss_s), .sck_s(sck_s),
    .mosi_s(mosi_s), .load(s_load), .tx_byte(reg_wdata), .miso(miso_o),
    .done(s_done), .rx_byte(s_rx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; flag_q <= 1'b0; armed_q <= 1'b0; rxbuf_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[5:0]);
      if (m_fault) ctrl_q.master <= 1'b0;
      if (m_done) rxbuf_q <= m_rx;
      else if (s_done) rxbuf_q <= s_rx;
      if (reg_rd && reg_addr == A_STAT && flag_q) armed_q <= 1'b1;
      if (data_acc && armed_q) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end
      if (m_done || s_done || m_fault) flag_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, ctrl_q};
      A_STAT:  reg_rdata = {flag_q, 7'b0};
      A_DATA:  reg_rdata = rxbuf_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq     = flag_q && ctrl_q.irq_en && glb_irq_en;
  assign sck_oe  = m_run;
  assign mosi_oe = m_run;
  assign miso_oe = s_run && !ss_s && ctrl_q.miso_en;
  assign ss_o    = ctrl_q.ss_level;
  assign ss_oe   = m_run && ctrl_q.ss_drive;

  assert_fault_demotes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_fault |=> (!ctrl_q.master && flag_q));
  assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(m_done || s_done || m_fault));
  assert_stays_slave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.master && !(reg_wr && reg_addr == A_CTRL)) |=> !ctrl_q.master);
  assert_drive_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_run && ctrl_q.ss_drive && !(reg_wr && reg_addr == A_CTRL)) |=> ctrl_q.master);
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  localparam int DIV_HALF = 4;
  localparam int SH = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0, glb_irq_en = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_i = 1;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] last_rx = 0;

  spi_port #(.DIV_HALF(DIV_HALF)) dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_flag();
    logic [7:0] d;
    rd(2'd1, d); rd(2'd2, d);
  endtask

  function automatic logic [7:0] bit_rev_none(logic [7:0] b);
    return b;  // MSB-first both ways: captured stream equals the byte
  endfunction

  task automatic mst_xfer(logic [7:0] tx, logic [7:0] sb,
                          output logic [7:0] cap, output int period);
    int t0;
    cap = 0; period = 0; t0 = 0;
    miso_i = sb[7];
    wr(2'd2, tx);
    for (int i = 0; i < 8; i++) begin
      @(posedge sck_o);
      cap = {cap[6:0], mosi_o};
      if (i == 1) period = cyc - t0;
      t0 = cyc;
      @(negedge sck_o);
      if (i < 7) miso_i = sb[6 - i];
    end
    idle(3);
  endtask

  task automatic slv_xfer(logic [7:0] b, int nbits, output logic [7:0] got);
    got = 0;
    for (int i = 0; i < nbits; i++) begin
      mosi_i = b[7 - i];
      idle(SH);
      got = {got[6:0], miso_o};
      sck_i = 1;
      idle(SH);
      sck_i = 0;
    end
    idle(SH);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, cap, sb, tx, got;
    int per;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 enables", {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);

    // R2/R3/R5 directed master transfer
    glb_irq_en = 1;
    wr(2'd0, 8'h07);
    chk("R7 oe on", {sck_oe, mosi_oe}, 2'b11);
    mst_xfer(8'hA5, 8'h3C, cap, per);
    chk("R2 mosi stream", cap, bit_rev_none(8'hA5));
    chk("R3 sck period", per, 2 * DIV_HALF);
    chk("R3 sck idle", sck_o, 0);
    rd(2'd1, d); chk("R2 flag set", d, 8'h80);
    chk("R5 irq on", irq, 1);
    rd(2'd2, d); chk("R2 rx byte", d, 8'h3C);
    rd(2'd1, d); chk("R4 cleared", d, 0);
    chk("R5 irq off", irq, 0);

    // R4 data access alone does not clear
    mst_xfer(8'h01, 8'h80, cap, per);
    rd(2'd2, d); chk("R2 rx byte", d, 8'h80);
    rd(2'd1, d); chk("R4 still set", d, 8'h80);
    glb_irq_en = 0; #1 chk("R5 gie off", irq, 0); glb_irq_en = 1;
    rd(2'd2, d); rd(2'd1, d); chk("R4 cleared", d, 0);

    // R2 random master transfers
    for (int k = 0; k < 6; k++) begin
      tx = 8'($urandom); sb = 8'($urandom);
      mst_xfer(tx, sb, cap, per);
      chk("R2 rand mosi", cap, tx);
      rd(2'd1, d); chk("R2 rand flag", d, 8'h80);
      rd(2'd2, d); chk("R2 rand rx", d, sb);
      last_rx = sb;
    end

    // R6 select as plain output
    wr(2'd0, 8'h1B);
    chk("R6 ss_oe", ss_oe, 1); chk("R6 ss_o", ss_o, 1);
    ss_i = 0;
    mst_xfer(8'h5A, 8'hC3, cap, per);
    rd(2'd0, d); chk("R6 master kept", d[1], 1);
    rd(2'd1, d); rd(2'd2, d); chk("R6 rx", d, 8'hC3);
    last_rx = 8'hC3;
    ss_i = 1; idle(4);

    // R7 mode fault mid-transfer
    wr(2'd0, 8'h07);
    wr(2'd2, 8'hF0);
    idle(10);
    ss_i = 0; idle(5);
    rd(2'd0, d); chk("R7 master cleared", d, 8'h05);
    chk("R7 oe dropped", {sck_oe, mosi_oe}, 0);
    chk("R7 irq", irq, 1);
    rd(2'd1, d); chk("R7 flag", d, 8'h80);
    rd(2'd2, d); chk("R7 data unchanged", d, last_rx);

    // R8 stays slave
    ss_i = 1; idle(10);
    rd(2'd0, d); chk("R8 still slave", d[1], 0);
    wr(2'd0, 8'h07);
    rd(2'd0, d); chk("R8 master again", d[1], 1);
    chk("R8 sck_oe", sck_oe, 1);

    // R9 passive slave
    wr(2'd0, 8'h21); idle(2);
    chk("R9 miso released", miso_oe, 0);
    slv_xfer(8'hFF, 8, got);
    rd(2'd1, d); chk("R9 no flag", d, 0);
    rd(2'd2, d); chk("R9 data kept", d, last_rx);

    // R10 selected slave transfers
    for (int k = 0; k < 4; k++) begin
      tx = (k == 0) ? 8'h96 : 8'($urandom);
      sb = 8'($urandom);
      wr(2'd2, tx);
      ss_i = 0; idle(4);
      chk("R10 miso_oe", miso_oe, 1);
      slv_xfer(sb, 8, got);
      chk("R10 miso stream", got, tx);
      rd(2'd1, d); chk("R10 flag", d, 8'h80);
      rd(2'd2, d); chk("R10 rx", d, sb);
      ss_i = 1; idle(4);
      chk("R9 miso released", miso_oe, 0);
    end
    wr(2'd0, 8'h01); ss_i = 0; idle(4);
    chk("R10 miso disabled", miso_oe, 0);
    ss_i = 1; idle(4);

    // R11 abort on select rising
    wr(2'd0, 8'h21);
    ss_i = 0; idle(4);
    slv_xfer(8'hE7, 3, got);
    ss_i = 1; idle(6);
    rd(2'd1, d); chk("R11 no flag", d, 0);
    ss_i = 0; idle(4);
    slv_xfer(8'h4B, 8, got);
    rd(2'd1, d); chk("R11 flag after full", d, 8'h80);
    rd(2'd2, d); chk("R11 clean rx", d, 8'h4B);
    ss_i = 1; idle(4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule